// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block merges up to 32 interrupt inputs into a single active-low request line for a processor. Each input has its own mode word and its own 32-bit vector word, both held in the block. The mode word gives a 3-bit priority and a trigger type: level or edge, with a polarity that may be active-high or active-low. Inputs are registered once, inverted when active-low, and then judged as a level or as a rising transition. The result is gated by a per-source enable mask and compared with the priority of the handler that is already running.

The processor uses a plain register bus with address, write strobe, read strobe, write data and read data. A read of the vector word does three things. It returns the vector of the winning source. It acknowledges that source, which clears its pending bit if the source is edge-triggered. It pushes the source's priority and number onto an eight-level nesting stack. While the stack holds a level, only a strictly higher priority can raise the request again. A write of any value to the end-of-interrupt word pops one level. If nothing qualifies, the vector read returns a programmable spurious value and changes no state.

Software sets and clears enable bits with one-hot command words, in which a written 0 has no effect. Separate command words force or clear edge pending bits, so software can retrigger a source.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The mode word of source n is at byte address 4*n. It holds the priority in bits [2:0], the edge select in bit 4 (1 = edge) and active-low polarity in bit 5, and its other bits read 0. The vector word of source n at 0x80+4*n, the spurious word at 0x134 and bit 0 of the debug word at 0x138 read back what was last written.
- R2: After reset the enable mask (0x110), pending word (0x10C), serviced number (0x108) and core status (0x114) read 0, and irq_n is 1.
- R3: A write to 0x120 sets every mask bit whose written bit is 1. A write to 0x124 clears every mask bit whose written bit is 1. Written 0 bits leave the mask unchanged.
- R4: The pending word shows, per source: for level sources, the registered input after polarity; for edge sources, a latch set by a sampled rising transition after polarity. The latch holds after the input returns to idle.
- R5: A source qualifies when it is pending, enabled, and its priority is strictly above the priority on top of the nesting stack (any priority qualifies when the stack is empty). irq_n is 0 exactly while a source qualifies, and bit 0 of 0x114 reads 1 exactly then.
- R6: Among qualifying sources the highest priority wins, and ties go to the lowest source number.
- R7: A read of 0x100 while a source qualifies returns the winner's vector word, pushes the winner onto the stack and clears its pending latch if it is edge-triggered. 0x108 then reads the source number on top of the stack, or 0 when the stack is empty.
- R8: A read of 0x100 while nothing qualifies returns the spurious word and leaves the stack unchanged.
- R9: A write of any value to 0x130 pops one stack level. On an empty stack it has no effect. The stack holds eight levels.
- R10: A write to 0x128 clears the pending latch of every edge source whose written bit is 1 and leaves level sources unchanged. A write to 0x12C forces the pending latch of every edge source whose written bit is 1.
- R11: An active-low level source is pending while its input is 0. An active-low edge source latches on a falling input transition, not on a rising one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Raw interrupt inputs, one per source |
| bus_addr | input | 9 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; it has side effects only at 0x100 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that the bus never raises its read and write strobes in the same cycle. They also assume that every access lasts exactly one cycle, so each acknowledge or pop is seen once. The bench tasks drive one strobe at a time for a single clock and change inputs only on the falling edge. The nesting checks assume the priority field cannot exceed seven. The bench never writes a wider value, because the mode word drops the upper bits.

// File: rtl/vic_pkg.sv
package vic_pkg;

  localparam int unsigned PRIO_W = 3;
  localparam int unsigned ADDR_W = 9;

  typedef logic [PRIO_W-1:0] prio_t;

  typedef struct packed {
    logic  low_act;
    logic  edge_sel;
    prio_t prio;
  } mode_t;

  localparam logic [ADDR_W-1:0] OFS_IVR  = 9'h100;
  localparam logic [ADDR_W-1:0] OFS_ISR  = 9'h108;
  localparam logic [ADDR_W-1:0] OFS_PEND = 9'h10C;
  localparam logic [ADDR_W-1:0] OFS_MASK = 9'h110;
  localparam logic [ADDR_W-1:0] OFS_CORE = 9'h114;
  localparam logic [ADDR_W-1:0] OFS_EN   = 9'h120;
  localparam logic [ADDR_W-1:0] OFS_DIS  = 9'h124;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 9'h128;
  localparam logic [ADDR_W-1:0] OFS_SET  = 9'h12C;
  localparam logic [ADDR_W-1:0] OFS_EOI  = 9'h130;
  localparam logic [ADDR_W-1:0] OFS_SPUR = 9'h134;
  localparam logic [ADDR_W-1:0] OFS_DBG  = 9'h138;

  // Mode word layout: [2:0] priority, [4] edge select, [5] active low.
  function automatic mode_t mode_from_word(input logic [31:0] w);
    mode_t m;
    m.low_act  = w[5];
    m.edge_sel = w[4];
    m.prio     = w[PRIO_W-1:0];
    return m;
  endfunction

  function automatic logic [31:0] mode_to_word(input mode_t m);
    return {26'd0, m.low_act, m.edge_sel, 1'b0, m.prio};
  endfunction

  // A candidate preempts only with a strictly higher priority.
  function automatic logic outranks(input prio_t cand, input prio_t top,
                                    input logic stack_empty);
    return stack_empty || (cand > top);
  endfunction

endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  input  logic edge_sel,
  input  logic low_act,
  input  logic clr_cmd,
  input  logic set_cmd,
  input  logic ack,
  output logic pending,
  output logic edge_evt
);

  logic smp_q;
  logic prev_q;
  logic latch_q;

  // Polarity is folded in before the level/edge decision.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      smp_q  <= raw_in ^ low_act;
      prev_q <= smp_q;
    end
  end

  assign edge_evt = smp_q & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
    end else if (!edge_sel) begin
      latch_q <= 1'b0;
    end else begin
      latch_q <= (latch_q & ~clr_cmd & ~ack) | edge_evt | set_cmd;
    end
  end

  assign pending = edge_sel ? latch_q : smp_q;

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter import vic_pkg::*; #(
  parameter int unsigned NSRC = 32,
  localparam int unsigned ID_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]             pend_vec,
  input  logic [NSRC-1:0]             mask_vec,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_vec,
  input  prio_t                       top_prio,
  input  logic                        stack_empty,
  output logic                        win_valid,
  output logic [ID_W-1:0]             win_id,
  output prio_t                       win_prio
);

  logic [NSRC-1:0] qual_vec;

  for (genvar g = 0; g < NSRC; g++) begin : g_qual
    assign qual_vec[g] = pend_vec[g] & mask_vec[g] &
                         outranks(prio_vec[g], top_prio, stack_empty);
  end

  // Ascending scan with strict compare keeps the lowest index on ties.
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_prio  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (qual_vec[i] && (!win_valid || prio_vec[i] > win_prio)) begin
        win_valid = 1'b1;
        win_id    = ID_W'(i);
        win_prio  = prio_vec[i];
      end
    end
  end

endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ID_W   = 5,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic [ID_W-1:0]   push_id,
  output logic [PRIO_W-1:0] top_prio,
  output logic [ID_W-1:0]   top_id,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  depth
);

  logic [PRIO_W-1:0] prio_mem [DEPTH];
  logic [ID_W-1:0]   id_mem   [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  top_idx;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign depth   = cnt_q;
  assign top_idx = cnt_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        prio_mem[i] <= '0;
        id_mem[i]   <= '0;
      end
    end else if (push && !full) begin
      prio_mem[cnt_q[PTR_W-1:0]] <= push_prio;
      id_mem[cnt_q[PTR_W-1:0]]   <= push_id;
      cnt_q                      <= cnt_q + 1'b1;
    end else if (pop && !empty) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign top_prio = empty ? '0 : prio_mem[top_idx[PTR_W-1:0]];
  assign top_id   = empty ? '0 : id_mem[top_idx[PTR_W-1:0]];

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl import vic_pkg::*; #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned ID_W  = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic [8:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_n
);

  mode_t [NSRC-1:0]             mode_all;
  logic  [NSRC-1:0][DATA_W-1:0] vec_all;
  logic  [NSRC-1:0][PRIO_W-1:0] prio_vec;
  logic  [NSRC-1:0]             pend_vec;
  logic  [NSRC-1:0]             edge_vec;
  logic  [NSRC-1:0]             clr_vec;
  logic  [NSRC-1:0]             set_vec;
  logic  [NSRC-1:0]             ack_vec;
  logic  [NSRC-1:0]             mask_q;
  logic  [DATA_W-1:0]           spur_q;
  logic                         dbg_q;

  logic                         win_valid;
  logic  [ID_W-1:0]             win_id;
  prio_t                        win_prio;

  logic                         push;
  logic                         pop;
  logic                         stk_empty;
  logic                         stk_full;
  prio_t                        top_prio;
  logic  [ID_W-1:0]             top_id;
  logic  [CNT_W-1:0]            depth;

  logic                         in_src_map;
  logic  [ID_W-1:0]             sel_idx;

  assign in_src_map = !bus_addr[8];
  assign sel_idx    = bus_addr[2 +: ID_W];

  // Named events shared with the checker.
  assign push    = bus_rd && (bus_addr == OFS_IVR) && win_valid;
  assign pop     = bus_wr && (bus_addr == OFS_EOI);
  assign clr_vec = (bus_wr && bus_addr == OFS_CLR) ? bus_wdata[NSRC-1:0] : '0;
  assign set_vec = (bus_wr && bus_addr == OFS_SET) ? bus_wdata[NSRC-1:0] : '0;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    mode_t             mode_r;
    logic [DATA_W-1:0] vec_r;
    logic              mode_we;
    logic              vec_we;

    assign mode_we = bus_wr && in_src_map && !bus_addr[7] && (sel_idx == ID_W'(g));
    assign vec_we  = bus_wr && in_src_map &&  bus_addr[7] && (sel_idx == ID_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_r <= '0;
        vec_r  <= '0;
      end else begin
        if (mode_we) mode_r <= mode_from_word(bus_wdata);
        if (vec_we)  vec_r  <= bus_wdata;
      end
    end

    assign mode_all[g] = mode_r;
    assign vec_all[g]  = vec_r;
    assign prio_vec[g] = mode_r.prio;
    assign ack_vec[g]  = push && (win_id == ID_W'(g));

    vic_src_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (src_in[g]),
      .edge_sel (mode_r.edge_sel),
      .low_act  (mode_r.low_act),
      .clr_cmd  (clr_vec[g]),
      .set_cmd  (set_vec[g]),
      .ack      (ack_vec[g]),
      .pending  (pend_vec[g]),
      .edge_evt (edge_vec[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      spur_q <= '0;
      dbg_q  <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_EN:   mask_q <= mask_q | bus_wdata[NSRC-1:0];
        OFS_DIS:  mask_q <= mask_q & ~bus_wdata[NSRC-1:0];
        OFS_SPUR: spur_q <= bus_wdata;
        OFS_DBG:  dbg_q  <= bus_wdata[0];
        default:  ;
      endcase
    end
  end

  vic_arbiter #(.NSRC(NSRC)) u_arb (
    .pend_vec    (pend_vec),
    .mask_vec    (mask_q),
    .prio_vec    (prio_vec),
    .top_prio    (top_prio),
    .stack_empty (stk_empty),
    .win_valid   (win_valid),
    .win_id      (win_id),
    .win_prio    (win_prio)
  );

  vic_nest_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .push_prio (win_prio),
    .push_id   (win_id),
    .top_prio  (top_prio),
    .top_id    (top_id),
    .empty     (stk_empty),
    .full      (stk_full),
    .depth     (depth)
  );

  assign irq_n = ~win_valid;

  always_comb begin
    bus_rdata = '0;
    if (in_src_map) begin
      if (bus_addr[7]) bus_rdata = vec_all[sel_idx];
      else             bus_rdata = DATA_W'(mode_to_word(mode_all[sel_idx]));
    end else begin
      case (bus_addr)
        OFS_IVR:  bus_rdata = win_valid ? vec_all[win_id] : spur_q;
        OFS_ISR:  bus_rdata = DATA_W'(top_id);
        OFS_PEND: bus_rdata = DATA_W'(pend_vec);
        OFS_MASK: bus_rdata = DATA_W'(mask_q);
        OFS_CORE: bus_rdata = DATA_W'(win_valid);
        OFS_SPUR: bus_rdata = spur_q;
        OFS_DBG:  bus_rdata = DATA_W'(dbg_q);
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/vic_checker.sv
module vic_checker import vic_pkg::*; #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [8:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             irq_n,
  input logic [NSRC-1:0]  pend_vec,
  input logic [NSRC-1:0]  mask_q,
  input logic             push,
  input prio_t            win_prio,
  input prio_t            top_prio,
  input logic [CNT_W-1:0] depth
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (depth < CNT_W'(DEPTH))); // R9

  AST_NEST_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (push && depth != '0) |-> (win_prio > top_prio)); // R5

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> ((pend_vec & mask_q) != '0)); // R5

  AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_IVR && !irq_n) |=> (depth == CNT_W'($past(depth) + 1'b1))); // R7

  AST_SPUR_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_IVR && irq_n) |=> $stable(depth)); // R8

  AST_EOI_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_EOI && depth != '0) |=> (depth == CNT_W'($past(depth) - 1'b1))); // R9

  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_EN) |=>
      ((mask_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0]))); // R3

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DIS) |=> ((mask_q & $past(bus_wdata[NSRC-1:0])) == '0)); // R3

endmodule

bind irq_vector_ctrl vic_checker #(.NSRC(NSRC), .DEPTH(DEPTH)) u_vic_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_n     (irq_n),
  .pend_vec  (pend_vec),
  .mask_q    (mask_q),
  .push      (push),
  .win_prio  (win_prio),
  .top_prio  (top_prio),
  .depth     (depth)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;

  localparam int NSRC = 32;
  localparam logic [31:0] SPUR = 32'hDEAD_5A5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [8:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src), .bus_addr(addr),
    .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata), .irq_n(irq_n)
  );

  function automatic logic [31:0] vec_of(input int i);
    return 32'hC000_0000 | (i << 8) | i;
  endfunction

  function automatic int prio_of(input int i);
    return (i * 3 + 1) % 8;
  endfunction

  function automatic int pick(input logic [31:0] pat);
    int best = -1;
    for (int i = 0; i < NSRC; i++)
      if (pat[i] && (best < 0 || prio_of(i) > prio_of(best))) best = i;
    return best;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #2 d = rdata;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic see_irq(input string req, input logic exp);
    @(negedge clk);
    chk(req, {31'd0, irq_n}, {31'd0, exp});
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pat;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R2: reset state
    see_irq("R2 irq_n", 1'b1);
    rd_reg(9'h110, v); chk("R2 mask", v, 0);
    rd_reg(9'h10C, v); chk("R2 pending", v, 0);
    rd_reg(9'h108, v); chk("R2 serviced", v, 0);
    rd_reg(9'h114, v); chk("R2 core", v, 0);

    // R1: register readback sweep
    for (int i = 0; i < NSRC; i++) begin
      wr_reg(9'(4 * i), 32'hFFFF_FF00 | 32'((i * 7) & 8'h3F));
      wr_reg(9'(9'h80 + 4 * i), vec_of(i));
    end
    for (int i = 0; i < NSRC; i++) begin
      rd_reg(9'(4 * i), v);
      chk("R1 mode", v, 32'((i * 7) & 8'h37));
      rd_reg(9'(9'h80 + 4 * i), v);
      chk("R1 vector", v, vec_of(i));
    end
    wr_reg(9'h134, SPUR); rd_reg(9'h134, v); chk("R1 spurious", v, SPUR);
    wr_reg(9'h138, 32'h1); rd_reg(9'h138, v); chk("R1 debug", v, 1);
    wr_reg(9'h138, 32'h0); rd_reg(9'h138, v); chk("R1 debug", v, 0);

    // R3: mask commands
    wr_reg(9'h120, 32'h0000_00F0); rd_reg(9'h110, v); chk("R3 enable", v, 32'hF0);
    wr_reg(9'h120, 32'h0000_0001); rd_reg(9'h110, v); chk("R3 enable", v, 32'hF1);
    wr_reg(9'h124, 32'h0000_0030); rd_reg(9'h110, v); chk("R3 disable", v, 32'hC1);
    wr_reg(9'h124, 32'h0);         rd_reg(9'h110, v); chk("R3 disable zero", v, 32'hC1);

    // level, active-high, priorities from prio_of
    for (int i = 0; i < NSRC; i++) wr_reg(9'(4 * i), 32'(prio_of(i)));
    wr_reg(9'h124, 32'hFFFF_FFFF);

    // R8: nothing qualifies
    rd_reg(9'h100, v); chk("R8 spurious", v, SPUR);

    // R4 (masked level inputs still pend), R5 (no request while masked)
    src = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    rd_reg(9'h10C, v); chk("R4 level pending", v, 32'hFFFF_FFFF);
    see_irq("R5 masked", 1'b1);
    src = '0;
    repeat (3) @(posedge clk);

    // single-source sweep
    for (int i = 0; i < NSRC; i++) begin
      wr_reg(9'h124, 32'hFFFF_FFFF);
      wr_reg(9'h120, 32'h1 << i);
      src = 32'h1 << i;
      repeat (2) @(posedge clk);
      rd_reg(9'h10C, v); chk("R4 level", v, 32'h1 << i);
      see_irq("R5 raise", 1'b0);
      rd_reg(9'h114, v); chk("R5 core", v, 1);
      rd_reg(9'h100, v); chk("R7 vector", v, vec_of(i));
      rd_reg(9'h108, v); chk("R7 serviced", v, 32'(i));
      see_irq("R5 equal prio held", 1'b1);
      rd_reg(9'h100, v); chk("R8 nested spurious", v, SPUR);
      src = '0;
      wr_reg(9'h130, 0);
      rd_reg(9'h108, v); chk("R9 pop", v, 0);
    end

    // R6: arbitration over input patterns
    wr_reg(9'h120, 32'hFFFF_FFFF);
    pat = 32'hACE1_1234;
    for (int k = 0; k < 28; k++) begin
      logic [31:0] p;
      int w;
      case (k)
        0: p = 32'hFFFF_FFFF;
        1: p = 32'h8000_0001;
        2: p = 32'h0101_0000;
        3: p = 32'h0000_0000;
        default: begin
          pat = {pat[30:0], pat[31] ^ pat[21] ^ pat[1] ^ pat[0]};
          p = (k % 2 == 0) ? pat : (pat & {pat[15:0], pat[31:16]});
        end
      endcase
      src = p;
      repeat (2) @(posedge clk);
      w = pick(p);
      rd_reg(9'h100, v);
      if (w < 0) chk("R8 none", v, SPUR);
      else begin
        chk("R6 winner", v, vec_of(w));
        wr_reg(9'h130, 0);
      end
    end
    src = '0;

    // R9: nesting across eight levels
    for (int i = 0; i < 8; i++) wr_reg(9'(4 * i), 32'(i));
    wr_reg(9'h20, 32'h7);
    repeat (3) @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      src[k] = 1'b1;
      repeat (2) @(posedge clk);
      rd_reg(9'h100, v); chk("R9 nest vector", v, vec_of(k));
      rd_reg(9'h108, v); chk("R9 nest top", v, 32'(k));
    end
    src[8] = 1'b1;
    repeat (2) @(posedge clk);
    see_irq("R5 strict above top", 1'b1);
    wr_reg(9'h130, 0);
    rd_reg(9'h108, v); chk("R9 after pop", v, 6);
    see_irq("R5 requalify", 1'b0);
    rd_reg(9'h100, v); chk("R6 tie low index", v, vec_of(7));
    src = '0;
    for (int j = 7; j >= 0; j--) begin
      wr_reg(9'h130, 0);
      rd_reg(9'h108, v); chk("R9 drain", v, (j > 0) ? 32'(j - 1) : 32'd0);
    end
    wr_reg(9'h130, 0);
    rd_reg(9'h108, v); chk("R9 empty pop", v, 0);
    see_irq("R9 empty pop irq", 1'b1);
    src[3] = 1'b1;
    repeat (2) @(posedge clk);
    rd_reg(9'h100, v); chk("R9 stack intact", v, vec_of(3));
    src = '0;
    wr_reg(9'h130, 0);

    // R4/R7/R10: edge source 20, level source 21
    wr_reg(9'h124, 32'hFFFF_FFFF);
    wr_reg(9'h120, 32'h0010_0000);
    wr_reg(9'(4 * 20), 32'h15);
    wr_reg(9'(4 * 21), 32'h02);
    wr_reg(9'h128, 32'h0010_0000);
    @(negedge clk); src[20] = 1'b1;
    @(negedge clk); src[20] = 1'b0;
    repeat (3) @(posedge clk);
    rd_reg(9'h10C, v); chk("R4 edge latched", v & 32'h0010_0000, 32'h0010_0000);
    rd_reg(9'h100, v); chk("R7 edge vector", v, vec_of(20));
    rd_reg(9'h10C, v); chk("R7 edge cleared", v & 32'h0010_0000, 0);
    wr_reg(9'h130, 0);
    @(negedge clk); src[20] = 1'b1;
    @(negedge clk); src[20] = 1'b0;
    repeat (3) @(posedge clk);
    wr_reg(9'h128, 32'h0010_0000);
    rd_reg(9'h10C, v); chk("R10 clear edge", v & 32'h0010_0000, 0);
    see_irq("R10 clear irq", 1'b1);
    wr_reg(9'h12C, 32'h0010_0000);
    rd_reg(9'h10C, v); chk("R10 set edge", v & 32'h0010_0000, 32'h0010_0000);
    see_irq("R10 set irq", 1'b0);
    wr_reg(9'h128, 32'h0010_0000);
    src[21] = 1'b1;
    repeat (2) @(posedge clk);
    wr_reg(9'h128, 32'h0020_0000);
    rd_reg(9'h10C, v); chk("R10 level unaffected", v & 32'h0020_0000, 32'h0020_0000);
    src[21] = 1'b0;

    // R11: active-low polarity
    wr_reg(9'(4 * 22), 32'h21);
    repeat (3) @(posedge clk);
    rd_reg(9'h10C, v); chk("R11 low level idle0", v & 32'h0040_0000, 32'h0040_0000);
    src[22] = 1'b1;
    repeat (2) @(posedge clk);
    rd_reg(9'h10C, v); chk("R11 low level high", v & 32'h0040_0000, 0);
    src[23] = 1'b1;
    repeat (2) @(posedge clk);
    wr_reg(9'(4 * 23), 32'h31);
    repeat (3) @(posedge clk);
    wr_reg(9'h128, 32'h0080_0000);
    src[23] = 1'b0;
    repeat (3) @(posedge clk);
    rd_reg(9'h10C, v); chk("R11 falling latches", v & 32'h0080_0000, 32'h0080_0000);
    wr_reg(9'h128, 32'h0080_0000);
    src[23] = 1'b1;
    repeat (3) @(posedge clk);
    rd_reg(9'h10C, v); chk("R11 rising ignored", v & 32'h0080_0000, 0);

    done = 1'b1;
    report();
    $finish;
  end

endmodule